// File: doc/BRIEF.md
# Chainable FIFO Slice with Token Hand-off

This block is one slice of a deep first-in/first-out buffer. It is built by linking several identical slices into a ring. Each slice owns a small local store. It also holds two tokens: a write token and a read token. A slice accepts a word only while it holds the write token, and it presents the oldest word only while it holds the read token. When a slice fills or drains its last physical location, it raises `pass_out` for that cycle. That pulse drives `pass_in` of the next slice in the ring, which then takes over the matching token. The last slice feeds the first, so both tokens circulate. Total depth is the slice count times `DEPTH`.

All slices share the write stream (`wr_valid`, `wr_data`) and the read strobe (`rd_ready`). A write is taken when `wr_valid` and `wr_ready` are both high at a rising clock edge. A read is taken when `rd_valid` and `rd_ready` are both high. Only the write-token holder can raise `wr_ready`, and only the read-token holder can raise `rd_valid`. As a result, the chain-level `wr_ready`, `rd_valid`, `full`, `empty` and `rd_data` are plain ORs of the slice outputs. Back-pressure works as follows. The producer must hold `wr_data` while `wr_valid` is high and `wr_ready` is low. While `rd_valid` is high and `rd_ready` is low, the word on `rd_data` stays put.

A slice tells write and read hand-offs apart by order. Tokens travel in one direction and the reader never overtakes the writer, so each slice receives a write token and then a read token, alternately. The slice that holds both tokens at reset expects the write token next. Refilling and retransmitting the whole buffer and a half-full indication are not part of this block.

Top module: `exp_fifo_slice`

## Requirements
- R1: While `rst_n` is low and after it rises, a slice with `lead_n`=0 holds both tokens. It shows `wr_ready`=1, `rd_oe`=1, `empty`=1, `rd_valid`=0 and `full`=0. A slice with `lead_n`=1 holds neither token. It shows `wr_ready`=0, `rd_oe`=0, `rd_valid`=0, `full`=0 and `empty`=0. All slices start with no stored words and with both pointers at location 0.
- R2: Across the ring, words leave in the order in which they were accepted. While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` do not change.
- R3: `wr_ready` is high only when the slice holds the write token and its location at the write pointer is free. `full` is high only when the slice holds the write token and all `DEPTH` locations are occupied. A chain of N slices therefore refuses writes after N*`DEPTH` unread words, and a write offered while full is dropped.
- R4: `empty` is high when the slice holds the read token and stores no word. In that state `rd_valid` is low and a read strobe has no effect.
- R5: `pass_out` is high exactly in a cycle in which the slice takes a write into location `DEPTH`-1 or a read from location `DEPTH`-1. The matching token leaves the slice at that clock edge.
- R6: A pulse on `pass_in` is sampled at the rising edge. It grants the write token if the slice expects the write token, and otherwise the read token. The expectation starts at "write" on reset and flips with every pulse received. `rd_oe` rises only in the cycle after a `pass_in` pulse.
- R7: A slice without the read token keeps `rd_oe`=0, `rd_valid`=0, `empty`=0 and `rd_data` all zero. A slice without the write token keeps `wr_ready`=0 and `full`=0. Strobes seen by such a slice change nothing.
- R8: A pointer that hands on its token wraps to location 0. When the token comes back around the ring, the slice again accepts or delivers exactly `DEPTH` words before the next `pass_out`.
- R9: A write and a read taken in the same cycle, in the same slice or in different slices, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lead_n | input | 1 | Low on the slice that owns both tokens after reset |
| wr_valid | input | 1 | Shared write request |
| wr_data | input | WIDTH | Shared write word |
| wr_ready | output | 1 | Slice takes the offered word this cycle |
| rd_valid | output | 1 | Slice presents a stored word |
| rd_data | output | WIDTH | Oldest word of the slice; zero without read token |
| rd_ready | input | 1 | Shared read request |
| rd_oe | output | 1 | Slice holds the read token and drives the read bus |
| full | output | 1 | Write-token holder with all locations occupied |
| empty | output | 1 | Read-token holder with no stored word |
| pass_in | input | 1 | Token hand-off pulse from the previous slice |
| pass_out | output | 1 | Token hand-off pulse to the next slice |

## Verification
The bound checker checks the per-slice rules on every cycle. It confirms that `full` excludes `wr_ready` and that `empty` excludes `rd_valid`. It checks that a slice without the read token stays silent, that a held word stays stable under back-pressure, that a last-location transfer releases its token, and that the read token appears only after a `pass_in` pulse. Some properties span the whole ring, and only the bench scenarios can show them. These are global ordering of words, the alternation of write and read grants, pointer wrap after a full lap, the chain-level full point at three times `DEPTH`, and dropped strobes at full and empty. The bench shows them by comparing a three-slice ring against a queue model on every clock, through fill, drain, mixed traffic and a mid-stream reset.

// File: rtl/efs_pkg.sv
package efs_pkg;
  // Which token a slice will accept on its next hand-off pulse.
  typedef enum logic {
    EXPECT_WR = 1'b0,
    EXPECT_RD = 1'b1
  } tok_expect_e;
endpackage

// File: rtl/efs_ptr.sv
module efs_ptr #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic          at_last
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_inc;

  generate
    if (POW2) begin : g_pow2
      // Natural binary roll-over returns to location 0.
      assign ptr_inc = ptr_q + AW'(1);
    end else begin : g_cmp
      assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (adv) ptr_q <= ptr_inc;
  end

  assign ptr     = ptr_q;
  assign at_last = (ptr_q == LAST);
endmodule

// File: rtl/efs_store.sv
module efs_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/efs_token.sv
module efs_token
  import efs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lead_n,
  input  logic pass_in,
  input  logic wr_rel,
  input  logic rd_rel,
  output logic wr_tok,
  output logic rd_tok
);
  tok_expect_e expect_q;
  logic        wr_q, rd_q;
  logic        grant_wr, grant_rd;

  assign grant_wr = pass_in && (expect_q == EXPECT_WR);
  assign grant_rd = pass_in && (expect_q == EXPECT_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= !lead_n;
      rd_q     <= !lead_n;
      expect_q <= EXPECT_WR;
    end else begin
      // Release first, then grant, so a one-slice ring keeps its token.
      wr_q <= (wr_q && !wr_rel) || grant_wr;
      rd_q <= (rd_q && !rd_rel) || grant_rd;
      if (pass_in)
        expect_q <= (expect_q == EXPECT_WR) ? EXPECT_RD : EXPECT_WR;
    end
  end

  assign wr_tok = wr_q;
  assign rd_tok = rd_q;
endmodule

// File: rtl/exp_fifo_slice.sv
module exp_fifo_slice #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lead_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rd_ready,
  output logic             rd_oe,
  output logic             full,
  output logic             empty,
  input  logic             pass_in,
  output logic             pass_out
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic          wr_tok, rd_tok;
  logic          wr_fire, rd_fire;
  logic          wr_last, rd_last;
  logic          wr_rel, rd_rel;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic [WIDTH-1:0] mem_rd;

  assign wr_ready = wr_tok && (cnt_q != CAP);
  assign rd_valid = rd_tok && (cnt_q != '0);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign wr_rel   = wr_fire && wr_last;
  assign rd_rel   = rd_fire && rd_last;
  assign pass_out = wr_rel || rd_rel;

  assign full     = wr_tok && (cnt_q == CAP);
  assign empty    = rd_tok && (cnt_q == '0);
  assign rd_oe    = rd_tok;
  assign rd_data  = rd_tok ? mem_rd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else begin
      unique case ({wr_fire, rd_fire})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  efs_token i_token (
    .clk    (clk),
    .rst_n  (rst_n),
    .lead_n (lead_n),
    .pass_in(pass_in),
    .wr_rel (wr_rel),
    .rd_rel (rd_rel),
    .wr_tok (wr_tok),
    .rd_tok (rd_tok)
  );

  efs_ptr #(.DEPTH(DEPTH)) i_wr_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (wr_fire),
    .ptr    (wr_ptr),
    .at_last(wr_last)
  );

  efs_ptr #(.DEPTH(DEPTH)) i_rd_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (rd_fire),
    .ptr    (rd_ptr),
    .at_last(rd_last)
  );

  efs_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_store (
    .clk  (clk),
    .we   (wr_fire),
    .waddr(wr_ptr),
    .wdata(wr_data),
    .raddr(rd_ptr),
    .rdata(mem_rd)
  );
endmodule

// File: rtl/efs_checker.sv
module efs_checker #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_ready,
  input logic             rd_oe,
  input logic             full,
  input logic             empty,
  input logic             pass_in,
  input logic             pass_out
);
  // R3: a full slice never offers to take a word.
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_ready);

  // R4: an empty slice never presents a word.
  p_empty_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_valid);

  // R7: no read token means a silent read side.
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0 && !rd_valid && !empty));

  // R2: a stalled word stays put.
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R5: a last-location write hands the write token away.
  p_wr_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_out && wr_valid && wr_ready && !(rd_valid && rd_ready) && !pass_in)
      |=> !wr_ready);

  // R5: a last-location read hands the read token away.
  p_rd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_out && rd_valid && rd_ready && !(wr_valid && wr_ready) && !pass_in)
      |=> !rd_oe);

  // R6: the read token only arrives by a hand-off pulse.
  p_rd_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> $past(pass_in));
endmodule

bind exp_fifo_slice efs_checker #(.WIDTH(WIDTH)) i_efs_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .rd_valid(rd_valid),
  .rd_data (rd_data),
  .rd_ready(rd_ready),
  .rd_oe   (rd_oe),
  .full    (full),
  .empty   (empty),
  .pass_in (pass_in),
  .pass_out(pass_out)
);

// File: tb/test_exp_fifo_slice.sv
module test_exp_fifo_slice;
  localparam int W   = 9;
  localparam int D   = 8;
  localparam int N   = 3;
  localparam int CAP = N * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic rd_ready = 1'b0;
  logic [W-1:0] wr_data = '0;

  logic [N-1:0] wr_ready_v, rd_valid_v, rd_oe_v, full_v, empty_v, pass_v;
  logic [W-1:0] rdd [N];
  logic [W-1:0] rd_data_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int q[$];
  int wcount = 0;
  int rcount = 0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_chain
    exp_fifo_slice #(.WIDTH(W), .DEPTH(D)) i_exp_fifo_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .lead_n  (g != 0),
      .wr_valid(wr_valid),
      .wr_data (wr_data),
      .wr_ready(wr_ready_v[g]),
      .rd_valid(rd_valid_v[g]),
      .rd_data (rdd[g]),
      .rd_ready(rd_ready),
      .rd_oe   (rd_oe_v[g]),
      .full    (full_v[g]),
      .empty   (empty_v[g]),
      .pass_in (pass_v[(g + N - 1) % N]),
      .pass_out(pass_v[g])
    );
  end

  always_comb begin
    rd_data_c = '0;
    for (int i = 0; i < N; i++) rd_data_c = rd_data_c | rdd[i];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endfunction

  // One clock: drive after the falling edge, compare, advance the model.
  task automatic step(input bit wv, input bit rr);
    int wslice, rslice, wloc, rloc, sz;
    logic [N-1:0] e_wr, e_rv, e_oe, e_full, e_empty, e_pass;
    bit wf, rf;
    string tag;
    @(negedge clk);
    wr_valid = wv;
    wr_data  = W'($urandom);
    rd_ready = rr;
    #1;
    sz     = q.size();
    wslice = (wcount / D) % N;
    rslice = (rcount / D) % N;
    wloc   = wcount % D;
    rloc   = rcount % D;
    wf     = wv && (sz < CAP);
    rf     = rr && (sz > 0);
    e_wr = '0; e_rv = '0; e_oe = '0; e_full = '0; e_empty = '0; e_pass = '0;
    e_wr[wslice]    = sz < CAP;
    e_full[wslice]  = sz == CAP;
    e_oe[rslice]    = 1'b1;
    e_rv[rslice]    = sz > 0;
    e_empty[rslice] = sz == 0;
    if (wf && wloc == D - 1) e_pass[wslice] = 1'b1;
    if (rf && rloc == D - 1) e_pass[rslice] = 1'b1;

    tag = (wcount == 0 && rcount == 0) ? "R1" : "R6";
    chk(rd_oe_v == e_oe, tag, rd_oe_v, e_oe);
    chk(wr_ready_v == e_wr, (wcount == 0) ? "R1" : "R3", wr_ready_v, e_wr);
    chk(full_v == e_full, "R3", full_v, e_full);
    chk(rd_valid_v == e_rv, "R4", rd_valid_v, e_rv);
    chk(empty_v == e_empty, (rcount == 0 && sz == 0) ? "R1" : "R4", empty_v, e_empty);
    chk(pass_v == e_pass, (wcount >= CAP || rcount >= CAP) ? "R8" : "R5", pass_v, e_pass);
    for (int i = 0; i < N; i++)
      if (i != rslice) chk(rdd[i] == '0, "R7", rdd[i], 0);
    if (sz > 0)
      chk(rd_data_c == W'(q[0]), (wf && rf) ? "R9" : "R2", rd_data_c, q[0]);

    if (rf) begin
      void'(q.pop_front());
      rcount++;
    end
    if (wf) begin
      q.push_back(int'(wr_data));
      wcount++;
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    wr_valid = 1'b0;
    rd_ready = 1'b0;
    repeat (3) @(posedge clk);
    q.delete();
    wcount = 0;
    rcount = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: idle cycles right after reset.
    repeat (3) step(1'b0, 1'b0);
    // R3: fill to the ring capacity and push against full.
    repeat (CAP + 6) step(1'b1, 1'b0);
    // R4: drain and keep reading while empty.
    repeat (CAP + 6) step(1'b0, 1'b1);
    // R8: several laps of the ring at half occupancy.
    repeat (CAP / 2) step(1'b1, 1'b0);
    // R9: steady concurrent reads and writes.
    repeat (4 * CAP) step(1'b1, 1'b1);
    // R2 / R6: mixed traffic with random back-pressure.
    for (int k = 0; k < 3000; k++) step(($urandom % 4) != 0, ($urandom % 3) != 0);
    repeat (20) step(1'b1, ($urandom % 5) == 0);
    // R1: reset in the middle of a stream.
    do_reset();
    repeat (2) step(1'b0, 1'b1);
    for (int k = 0; k < 500; k++) step($urandom % 2 == 1, $urandom % 2 == 1);
    repeat (CAP + 2) step(1'b0, 1'b1);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule